// File: doc/BRIEF.md
# Unified Data Memory with Frame Buffer and Key Input

This block is the data side of a small 16-bit processor. One flat word address space covers three regions. General working RAM fills the lower half. A frame-buffer RAM holding a monochrome picture fills the next quarter. A single read-only word carries the code of the key now held down, or zero when no key is held. The processor port has an address, write data, a load strobe and combinational read data. Writes land on the rising clock edge. An address decoder steers each access to its region. Accesses that fall beyond the key word read back zero and never change any storage.

A second, read-only raster port lets a display engine fetch picture words. The engine gives a pixel row and a word column, and the matching word appears one clock later. This port works whatever the processor port is doing. The picture is packed row-major, 32 words per row and 16 pixels per word, and a set bit marks a black pixel.

The block is parameterised by the address width `ADDR_W`:
- RAM holds 2^(ADDR_W-1) words.
- The frame buffer holds 2^(ADDR_W-2) words.
- The key word sits at the first address after the frame buffer.

With `ADDR_W` = 15 this gives the following map:

| Region | Addresses | Size / shape |
|---|---|---|
| RAM | 0..16383 | 16K words |
| Frame buffer | 16384..24575 | 8K words, a 256-row by 512-pixel picture |
| Key word | 24576 | one word |

Top module: `memSubsystem`

## Requirements
- R1: An address below RAM_WORDS = 2^(ADDR_W-1) reads and writes the general RAM word with that index.
- R2: An address from RAM_WORDS to KEY_ADDR-1 (KEY_ADDR = RAM_WORDS + 2^(ADDR_W-2)) reads and writes frame-buffer word (address - RAM_WORDS).
- R3: Address KEY_ADDR reads back the present value of `keyIn`, where 0 means no key is held.
- R4: `procOut` follows `procAddr` without a clock. Storage changes only on a rising edge with `load` = 1, so a write with `load` = 0 leaves every word unchanged.
- R5: A write to KEY_ADDR or to any higher address changes no RAM word, no frame-buffer word and not the key value read back.
- R6: A read of any address above KEY_ADDR returns 0.
- R7: `rasterOut` shows frame-buffer word `rowSel`*32 + `colSel` one clock after those inputs are sampled, whatever the processor port does.
- R8: When the processor writes a frame-buffer word in the same cycle that the raster port reads it, the raster port returns the contents from before the write.
- R9: Pixel (row, col) is bit col mod 16 of frame-buffer word 32*row + col/16, and a 1 marks black.
- R10: While `rstN` is low, `rasterOut` is cleared to 0 at each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset of the raster output register |
| procAddr | input | ADDR_W | Processor word address |
| dataIn | input | DATA_W | Processor write data |
| load | input | 1 | Write strobe, sampled on the rising edge |
| procOut | output | DATA_W | Combinational read data for `procAddr` |
| keyIn | input | DATA_W | Code of the key held down, 0 when none |
| rowSel | input | ADDR_W-2-COL_W | Raster pixel row |
| colSel | input | COL_W | Raster word column within the row |
| rasterOut | output | DATA_W | Registered frame-buffer word for the raster request |

## Verification
The bench builds the block with `ADDR_W` = 11, `DATA_W` = 16 and `COL_W` = 5. This gives 1024 RAM words, a 512-word frame buffer of 16 rows, and the key word at 1536. These sizes are small enough that every word of both regions is filled first. After that, each read on either port is compared against the model.

The edges 1023/1024, 1535/1536 and 1537 are reached directly, as is the top address 2047. Writes to the key word and to 1537 and above are shown to leave the aliased RAM and frame-buffer words intact. A raster read that collides with a processor write to the same word is checked, and so is setting a pixel and reading it back through the raster port. A long random phase then mixes all regions, both ports and key changes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Strobes from the address decoder to the storage datapath
  typedef struct packed {
    logic selRam;
    logic selFb;
    logic selKey;
    logic ramWr;
    logic fbWr;
  } memStrobes_t;

endpackage

// File: rtl/memCtrl.sv
module memCtrl
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] procAddr,
  input  logic              load,
  output memStrobes_t       strb
);
  localparam int RAM_WORDS = 1 << (ADDR_W - 1);
  localparam int FB_WORDS  = 1 << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(RAM_WORDS + FB_WORDS);

  always_comb begin
    // Lower half: RAM; next quarter ("10" prefix): frame buffer
    strb.selRam = ~procAddr[ADDR_W-1];
    strb.selFb  = (procAddr[ADDR_W-1 -: 2] == 2'b10);
    strb.selKey = (procAddr == KEY_ADDR);
    // Key word and everything above it never receive a write
    strb.ramWr  = load & strb.selRam;
    strb.fbWr   = load & strb.selFb;
  end
endmodule

// File: rtl/memDatapath.sv
module memDatapath
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int COL_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  memStrobes_t               strb,
  input  logic [ADDR_W-2:0]         ramIdx,
  input  logic [ADDR_W-3:0]         fbIdx,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic [DATA_W-1:0]         keyIn,
  input  logic [ADDR_W-3-COL_W:0]   rowSel,
  input  logic [COL_W-1:0]          colSel,
  output logic [DATA_W-1:0]         procOut,
  output logic [DATA_W-1:0]         rasterOut
);
  localparam int RAM_AW    = ADDR_W - 1;
  localparam int FB_AW     = ADDR_W - 2;
  localparam int RAM_WORDS = 1 << RAM_AW;
  localparam int FB_WORDS  = 1 << FB_AW;

  logic [DATA_W-1:0] ramMem [RAM_WORDS];
  logic [DATA_W-1:0] fbMem  [FB_WORDS];
  logic [FB_AW-1:0]  rasterIdx;

  // Row-major packing: word index is row followed by column bits
  assign rasterIdx = {rowSel, colSel};

  always_ff @(posedge clk) begin
    if (strb.ramWr) ramMem[ramIdx] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (strb.fbWr) fbMem[fbIdx] <= dataIn;
  end

  // Registered raster read; a same-edge write is not yet visible here
  always_ff @(posedge clk) begin
    if (!rstN) rasterOut <= '0;
    else       rasterOut <= fbMem[rasterIdx];
  end

  always_comb begin
    if (strb.selRam)      procOut = ramMem[ramIdx];
    else if (strb.selFb)  procOut = fbMem[fbIdx];
    else if (strb.selKey) procOut = keyIn;
    else                  procOut = '0;
  end
endmodule

// File: rtl/memSubsystem.sv
module memSubsystem
  import memmap_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int COL_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         procAddr,
  input  logic [DATA_W-1:0]         dataIn,
  input  logic                      load,
  output logic [DATA_W-1:0]         procOut,
  input  logic [DATA_W-1:0]         keyIn,
  input  logic [ADDR_W-3-COL_W:0]   rowSel,
  input  logic [COL_W-1:0]          colSel,
  output logic [DATA_W-1:0]         rasterOut
);
  memStrobes_t strb;

  memCtrl #(.ADDR_W(ADDR_W)) ctrl (
    .procAddr(procAddr),
    .load    (load),
    .strb    (strb)
  );

  memDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ramIdx   (procAddr[ADDR_W-2:0]),
    .fbIdx    (procAddr[ADDR_W-3:0]),
    .dataIn   (dataIn),
    .keyIn    (keyIn),
    .rowSel   (rowSel),
    .colSel   (colSel),
    .procOut  (procOut),
    .rasterOut(rasterOut)
  );
endmodule

// File: rtl/memSubsystem_chk.sv
module memSubsystem_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] procAddr,
  input logic [DATA_W-1:0] dataIn,
  input logic              load,
  input logic [DATA_W-1:0] procOut,
  input logic [DATA_W-1:0] keyIn
);
  localparam int RAM_WORDS = 1 << (ADDR_W - 1);
  localparam int KEY_ADDR  = RAM_WORDS + (1 << (ADDR_W - 2));

  AST_RAM_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(load) && (int'($past(procAddr)) < RAM_WORDS) && procAddr == $past(procAddr))
      |-> procOut == $past(dataIn)); // R1

  AST_FB_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(load) && (int'($past(procAddr)) >= RAM_WORDS) && (int'($past(procAddr)) < KEY_ADDR)
      && procAddr == $past(procAddr))
      |-> procOut == $past(dataIn)); // R2

  AST_KEY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (int'(procAddr) == KEY_ADDR) |-> procOut == keyIn); // R3

  AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(load) && procAddr == $past(procAddr) && (int'(procAddr) < KEY_ADDR))
      |-> procOut == $past(procOut)); // R4

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (int'(procAddr) > KEY_ADDR) |-> procOut == '0); // R6
endmodule

bind memSubsystem memSubsystem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .procAddr(procAddr),
  .dataIn  (dataIn),
  .load    (load),
  .procOut (procOut),
  .keyIn   (keyIn)
);

// File: tb/memSubsystem_test.sv
`timescale 1ns/1ps
module memSubsystem_test;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int COL_W  = 5;
  localparam int ROW_W  = ADDR_W - 2 - COL_W;
  localparam int RAM_N  = 1024;
  localparam int FB_N   = 512;
  localparam int FB_B   = 1024;
  localparam int KEY_A  = 1536;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] procAddr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic load = 1'b0;
  logic [DATA_W-1:0] procOut;
  logic [DATA_W-1:0] keyIn = '0;
  logic [ROW_W-1:0] rowSel = '0;
  logic [COL_W-1:0] colSel = '0;
  logic [DATA_W-1:0] rasterOut;

  always #2.5 clk = ~clk;

  memSubsystem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) uut (
    .clk(clk), .rstN(rstN), .procAddr(procAddr), .dataIn(dataIn), .load(load),
    .procOut(procOut), .keyIn(keyIn), .rowSel(rowSel), .colSel(colSel),
    .rasterOut(rasterOut)
  );

  int cmpCount = 0;
  int errCount = 0;
  bit done = 0;

  logic [DATA_W-1:0] ramM [int];
  logic [DATA_W-1:0] fbM  [int];
  bit rastPend = 0;
  logic [DATA_W-1:0] rastExp;
  string rastTag = "R7";

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    cmpCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock of stimulus; compares both ports against the behavioural model
  task automatic cycle(input int a, input logic [DATA_W-1:0] d, input bit ld,
                       input int r, input int c, input string tag);
    bit known;
    logic [DATA_W-1:0] ev;
    @(negedge clk);
    procAddr = ADDR_W'(a); dataIn = d; load = ld;
    rowSel = ROW_W'(r); colSel = COL_W'(c);
    #1;
    if (rastPend) chk(rastTag, rasterOut, rastExp);
    known = 1; ev = '0;
    if (a < RAM_N) begin
      if (ramM.exists(a)) ev = ramM[a]; else known = 0;
    end else if (a < KEY_A) begin
      if (fbM.exists(a - FB_B)) ev = fbM[a - FB_B]; else known = 0;
    end else if (a == KEY_A) ev = keyIn;
    else ev = '0;
    if (known) chk(tag, procOut, ev);
    rastTag = (tag == "R8" || tag == "R9") ? tag : "R7";
    rastPend = fbM.exists(r * 32 + c);
    if (rastPend) rastExp = fbM[r * 32 + c];   // old contents: R8
    if (ld) begin
      if (a < RAM_N) ramM[a] = d;
      else if (a < KEY_A) fbM[a - FB_B] = d;  // R5: nothing else changes
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errCount++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, errCount);
    $finish;
  end

  initial begin
    keyIn = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", rasterOut, '0);
    rstN = 1'b1;

    for (int i = 0; i < RAM_N; i++) cycle(i, 16'(i * 37 + 5), 1, 0, 0, "R1");
    for (int i = 0; i < FB_N; i++) cycle(FB_B + i, 16'({i[7:0], ~i[7:0]}), 1, i / 32, i % 32, "R2");

    // Region edges
    cycle(1023, 16'hA1A1, 1, 0, 0, "R1");
    cycle(1023, 16'h0, 0, 0, 0, "R1");
    cycle(1024, 16'hB2B2, 1, 0, 0, "R2");
    cycle(1024, 16'h0, 0, 0, 0, "R2");
    cycle(1535, 16'hC3C3, 1, 15, 31, "R2");
    cycle(1535, 16'h0, 0, 15, 31, "R7");
    keyIn = 16'h0041;
    cycle(KEY_A, 16'h0, 0, 0, 0, "R3");
    keyIn = 16'h0000;
    cycle(KEY_A, 16'h0, 0, 0, 0, "R3");
    cycle(KEY_A, 16'hDEAD, 1, 0, 0, "R5");
    cycle(KEY_A, 16'h0, 0, 0, 0, "R5");
    cycle(1537, 16'hBEEF, 1, 0, 0, "R5");
    cycle(1537, 16'h0, 0, 0, 0, "R6");
    cycle(2047, 16'hFACE, 1, 0, 0, "R5");
    cycle(2047, 16'h0, 0, 0, 0, "R6");
    // Aliases of the ignored writes stay untouched
    cycle(0, 16'h0, 0, 0, 0, "R5");
    cycle(512, 16'h0, 0, 0, 0, "R5");
    cycle(513, 16'h0, 0, 0, 0, "R5");
    cycle(1023, 16'h0, 0, 0, 0, "R5");
    cycle(1024, 16'h0, 0, 0, 0, "R5");
    cycle(1025, 16'h0, 0, 0, 0, "R5");
    cycle(1535, 16'h0, 0, 0, 0, "R5");
    // No load: no change
    cycle(5, 16'h7777, 0, 0, 0, "R4");
    cycle(5, 16'h0, 0, 0, 0, "R4");
    cycle(1100, 16'h7777, 0, 0, 0, "R4");
    cycle(1100, 16'h0, 0, 0, 0, "R4");

    // Collision: write word 162 while raster reads row 5 col 2
    cycle(FB_B + 162, 16'h1234, 1, 5, 2, "R8");
    cycle(FB_B + 162, 16'h0, 0, 5, 2, "R7");
    cycle(0, 16'h0, 0, 0, 0, "R7");

    // Pixel (5,37): word 162 bit 5
    cycle(FB_B + 162, 16'h0020, 1, 0, 0, "R9");
    cycle(0, 16'h0, 0, 5, 2, "R9");
    @(negedge clk); #1;
    chk("R9", {15'b0, rasterOut[5]}, 16'h0001);
    chk("R9", rasterOut, 16'h0020);
    // Pixel (0,511): word 31 bit 15
    cycle(FB_B + 31, 16'h8000, 1, 0, 0, "R9");
    cycle(0, 16'h0, 0, 0, 31, "R9");
    @(negedge clk); #1;
    chk("R9", rasterOut, 16'h8000);

    // Random mix on both ports
    for (int n = 0; n < 3000; n++) begin
      int a;
      a = int'($urandom_range(0, 2047));
      if (n % 10 == 0) keyIn = 16'($urandom);
      cycle(a, 16'($urandom), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 31)),
            a < RAM_N ? "R1" : a < KEY_A ? "R2" : a == KEY_A ? "R3" : "R6");
    end

    // Reset clears the raster register again
    @(negedge clk); rstN = 1'b0; load = 1'b0;
    @(negedge clk);
    chk("R10", rasterOut, '0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCount, errCount);
    $finish;
  end
endmodule